// File: doc/BRIEF.md
# Multi-Mode 8/16-Bit Timer Counter

This block is a timer/counter behind a small byte-wide register port. It counts either as one 16-bit register or in its low byte only. A three-bit mode field selects the width, a clear-on-compare (CTC) behaviour and input capture. Counting is driven by a tick. The tick comes from one of four prescaler taps supplied from outside, from the system clock, or from an external pin. That pin passes through a two-flop synchronizer and an edge detector.

Three flags are kept: overflow, compare match and capture. Each flag drives its own interrupt request output, and each is cleared by writing a one to its bit. The overflow flag always follows the absolute maximum of the active width. It does not follow the active TOP, so a CTC run that stays below MAX never raises it. A CPU write to the count always beats an increment or a clear in the same cycle.

Register map (3-bit `addr`): 0 count low byte, 1 count high byte, 2 compare A, 3 compare B, 4 control, 5 flags, 6 capture low byte, 7 capture high byte. Control bits [2:0] are the tick select, bit 3 is the waveform bit, bit 4 is width (1 = 16-bit) and bit 5 is capture enable. Flag bits: 0 overflow, 1 compare match, 2 capture.

Top module: `mode_timer`

## Requirements
- R1: After reset, the count, compare, control, flag and capture registers all read 0, and all three interrupt outputs are low.
- R2: With tick select 0, the count holds its value; the count bytes can still be written and read back.
- R3: With tick select 1 in mode {cap,width,wgm}=000, the low byte increments once per clock and wraps from 0xFF to 0x00, setting flag bit 0; the high byte is left untouched.
- R4: In mode 010 the full 16-bit count increments; 0x00FF to 0x0100 sets no flag, while 0xFFFF to 0x0000 sets flag bit 0.
- R5: In mode 001, the tick that finds the low byte equal to compare A loads 0 and sets flag bit 1.
- R6: In mode 011 the TOP is {compare B, compare A}, and the 16-bit count restarts from 0 at that value and sets flag bit 1.
- R7: Flag bit 0 is set on the tick at MAX (0xFF or 0xFFFF) in every mode, including CTC with the count above TOP, and then the count wraps to 0.
- R8: A CPU write to a count byte in the same cycle as a tick, even one at TOP, stores the written value with no increment, no clear and no compare flag.
- R9: A compare-register write is used from the next tick on, without waiting for TOP or BOTTOM.
- R10: Tick select 2..5 counts only on cycles where prescaler tap (select-2) is high; the other taps have no effect.
- R11: Tick select 7 counts rising and select 6 counts falling edges of the external input, once per edge; the count changes on the third clock edge after the input changes.
- R12: In modes with capture enable set, a rising edge on the capture input copies the count into the capture register and sets flag bit 2; in other modes it has no effect.
- R13: Writing 1 to a flag bit clears only that flag; each interrupt output equals its flag.
- R14: Reserved modes 101 and 111 count as the normal mode of their width, with no compare clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| tap_tick | input | 4 | Prescaler tap pulses, tap n selected by tick select n+2 |
| ext_clk_in | input | 1 | External count input, asynchronous |
| cap_in | input | 1 | Capture trigger input, asynchronous |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare-match interrupt request |
| irq_cap | output | 1 | Capture interrupt request |

## Verification
The bench targets the places where TOP and MAX part ways. A CTC count loaded above compare A must still reach 0xFF and raise overflow. A design that tied overflow to TOP would miss that flag or restart too early, and one that ignored compare B would never end the 16-bit CTC period. A count write is timed to land exactly on the tick that would have cleared at TOP; a design that gave counting priority reads back one too far or raises a spurious compare flag. The external-edge tests count edges of each polarity and check the three-edge latency. Getting either wrong shows up as double counting or an early increment. The capture tests hold the count still and pulse the trigger both inside and outside capture modes, so a capture that ignores the mode alters the capture register.

// File: rtl/mode_timer_pkg.sv
package mode_timer_pkg;

  typedef enum logic [2:0] {
    RA_CNT_LO = 3'd0,
    RA_CNT_HI = 3'd1,
    RA_CMP_A  = 3'd2,
    RA_CMP_B  = 3'd3,
    RA_CTRL   = 3'd4,
    RA_FLAGS  = 3'd5,
    RA_CAP_LO = 3'd6,
    RA_CAP_HI = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic       cap_en;
    logic       wide;
    logic       wgm;
    logic [2:0] csel;
  } ctrl_t;

  localparam int unsigned CTRL_W  = $bits(ctrl_t);
  localparam int unsigned FLG_OVF = 0;
  localparam int unsigned FLG_CMP = 1;
  localparam int unsigned FLG_CAP = 2;

  // Clear-on-compare only without capture enable; reserved codes fall to normal.
  function automatic logic is_ctc(input ctrl_t c);
    return !c.cap_en && c.wgm;
  endfunction

endpackage

// File: rtl/mt_edge_sync.sv
module mt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/mt_tick_sel.sv
module mt_tick_sel #(
  parameter int unsigned N_TAPS = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        csel,
  input  logic [N_TAPS-1:0] taps,
  input  logic              ext_in,
  output logic              tick
);
  localparam int unsigned N_SRC  = 8;
  localparam int unsigned TAP_LO = 2;
  localparam int unsigned TAP_SLOTS = 4;

  logic             ext_rise;
  logic             ext_fall;
  logic [N_SRC-1:0] src;

  mt_edge_sync #(.STAGES(SYNC_STAGES)) u_ext (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ext_in),
    .rise (ext_rise),
    .fall (ext_fall)
  );

  assign src[0] = 1'b0;
  assign src[1] = 1'b1;
  assign src[6] = ext_fall;
  assign src[7] = ext_rise;

  for (genvar g = 0; g < TAP_SLOTS; g++) begin : g_tap
    if (g < N_TAPS) begin : g_on
      assign src[g+TAP_LO] = taps[g];
    end else begin : g_off
      assign src[g+TAP_LO] = 1'b0;
    end
  end

  assign tick = src[csel];

  AST_TICK_OFF_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (csel == 3'd0) |-> !tick); // R2
endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int unsigned BW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wide,
  input  logic            ctc,
  input  logic            tick,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [BW-1:0]   wdata,
  input  logic [BW-1:0]   cmp_a,
  input  logic [BW-1:0]   cmp_b,
  input  logic            clr_ovf,
  input  logic            clr_cmp,
  output logic [2*BW-1:0] count,
  output logic            ovf_flag,
  output logic            cmp_flag
);
  localparam int unsigned CW = 2 * BW;

  logic [CW-1:0] cnt_q, cnt_d, act, top_val, max_val;
  logic          at_max, at_top, cpu_wr, ovf_set, cmp_set;
  logic          ovf_q, ovf_d, cmp_q, cmp_d;

  always_comb begin
    cpu_wr  = wr_lo | wr_hi;
    max_val = wide ? {CW{1'b1}} : {{BW{1'b0}}, {BW{1'b1}}};
    act     = wide ? cnt_q : {{BW{1'b0}}, cnt_q[BW-1:0]};
    if (ctc) top_val = wide ? {cmp_b, cmp_a} : {{BW{1'b0}}, cmp_a};
    else     top_val = max_val;
    at_max  = (act == max_val);
    at_top  = (act == top_val);
    cnt_d   = cnt_q;
    ovf_set = 1'b0;
    cmp_set = 1'b0;
    if (cpu_wr) begin
      if (wr_lo) cnt_d[BW-1:0]  = wdata;
      if (wr_hi) cnt_d[CW-1:BW] = wdata;
    end else if (tick) begin
      if (wide) cnt_d = (at_max || at_top) ? '0 : cnt_q + CW'(1);
      else      cnt_d[BW-1:0] = (at_max || at_top) ? '0 : cnt_q[BW-1:0] + BW'(1);
      ovf_set = at_max;
      cmp_set = ctc && at_top;
    end
    ovf_d = (ovf_q & ~clr_ovf) | ovf_set;
    cmp_d = (cmp_q & ~clr_cmp) | cmp_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      cmp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      cmp_q <= cmp_d;
    end
  end

  assign count    = cnt_q;
  assign ovf_flag = ovf_q;
  assign cmp_flag = cmp_q;

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_lo && !wr_hi) |=> $stable(count)); // R2
  AST_CPU_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (count[BW-1:0] == $past(wdata))); // R8
  AST_OVF_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_lo && !wr_hi && at_max) |=> (ovf_flag && count[BW-1:0] == '0)); // R7
  AST_CTC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_lo && !wr_hi && ctc && at_top) |=> (cmp_flag && count[BW-1:0] == '0)); // R5
  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && !ovf_set) |=> !ovf_flag); // R13
endmodule

// File: rtl/mt_capture.sv
module mt_capture #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_mode,
  input  logic          cap_edge,
  input  logic [CW-1:0] count,
  input  logic          clr_cap,
  output logic [CW-1:0] cap_val,
  output logic          cap_flag
);
  logic [CW-1:0] val_q, val_d;
  logic          flg_q, flg_d, take;

  always_comb begin
    take  = cap_mode & cap_edge;
    val_d = take ? count : val_q;
    flg_d = (flg_q & ~clr_cap) | take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      flg_q <= 1'b0;
    end else begin
      val_q <= val_d;
      flg_q <= flg_d;
    end
  end

  assign cap_val  = val_q;
  assign cap_flag = flg_q;

  AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode && cap_edge) |=> (cap_val == $past(count) && cap_flag)); // R12
  AST_CAPTURE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_mode |=> $stable(cap_val)); // R12
endmodule

// File: rtl/mode_timer.sv
module mode_timer
  import mode_timer_pkg::*;
#(
  parameter int unsigned BW          = 8,
  parameter int unsigned N_TAPS      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          CAP_ON_RISE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [BW-1:0]     wdata,
  output logic [BW-1:0]     rdata,
  input  logic [N_TAPS-1:0] tap_tick,
  input  logic              ext_clk_in,
  input  logic              cap_in,
  output logic              irq_ovf,
  output logic              irq_cmp,
  output logic              irq_cap
);
  localparam int unsigned CW = 2 * BW;

  logic [1:0]    rst_pipe;
  logic          rst_int_n;
  ctrl_t         ctrl_q, ctrl_d;
  logic [BW-1:0] cmp_a_q, cmp_a_d, cmp_b_q, cmp_b_d;
  logic          tick, cap_rise, cap_fall, cap_edge;
  logic [CW-1:0] count, cap_val;
  logic          ovf_flag, cmp_flag, cap_flag;
  logic          wr_lo, wr_hi, wr_flags;
  reg_addr_e     ra;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_comb begin
    ra       = reg_addr_e'(addr);
    wr_lo    = wr_en && (ra == RA_CNT_LO);
    wr_hi    = wr_en && (ra == RA_CNT_HI);
    wr_flags = wr_en && (ra == RA_FLAGS);
    ctrl_d   = ctrl_q;
    cmp_a_d  = cmp_a_q;
    cmp_b_d  = cmp_b_q;
    if (wr_en && ra == RA_CTRL)  ctrl_d  = ctrl_t'(wdata[CTRL_W-1:0]);
    if (wr_en && ra == RA_CMP_A) cmp_a_d = wdata;
    if (wr_en && ra == RA_CMP_B) cmp_b_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q  <= '0;
      cmp_a_q <= '0;
      cmp_b_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      cmp_a_q <= cmp_a_d;
      cmp_b_q <= cmp_b_d;
    end
  end

  mt_tick_sel #(.N_TAPS(N_TAPS), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk   (clk),
    .rst_n (rst_int_n),
    .csel  (ctrl_q.csel),
    .taps  (tap_tick),
    .ext_in(ext_clk_in),
    .tick  (tick)
  );

  mt_counter #(.BW(BW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wide    (ctrl_q.wide),
    .ctc     (is_ctc(ctrl_q)),
    .tick    (tick),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wdata   (wdata),
    .cmp_a   (cmp_a_q),
    .cmp_b   (cmp_b_q),
    .clr_ovf (wr_flags && wdata[FLG_OVF]),
    .clr_cmp (wr_flags && wdata[FLG_CMP]),
    .count   (count),
    .ovf_flag(ovf_flag),
    .cmp_flag(cmp_flag)
  );

  mt_edge_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  (cap_in),
    .rise (cap_rise),
    .fall (cap_fall)
  );

  if (CAP_ON_RISE) begin : g_cap_rise
    assign cap_edge = cap_rise;
  end else begin : g_cap_fall
    assign cap_edge = cap_fall;
  end

  mt_capture #(.CW(CW)) u_cap (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cap_mode(ctrl_q.cap_en),
    .cap_edge(cap_edge),
    .count   (count),
    .clr_cap (wr_flags && wdata[FLG_CAP]),
    .cap_val (cap_val),
    .cap_flag(cap_flag)
  );

  always_comb begin
    unique case (ra)
      RA_CNT_LO: rdata = count[BW-1:0];
      RA_CNT_HI: rdata = count[CW-1:BW];
      RA_CMP_A:  rdata = cmp_a_q;
      RA_CMP_B:  rdata = cmp_b_q;
      RA_CTRL:   rdata = BW'(ctrl_q);
      RA_FLAGS:  rdata = BW'({cap_flag, cmp_flag, ovf_flag});
      RA_CAP_LO: rdata = cap_val[BW-1:0];
      default:   rdata = cap_val[CW-1:BW];
    endcase
  end

  assign irq_ovf = ovf_flag;
  assign irq_cmp = cmp_flag;
  assign irq_cap = cap_flag;

  AST_IRQ_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_flags && wdata[FLG_CMP] && !tick) |=> !irq_cmp); // R13
endmodule

// File: tb/sim_mode_timer.sv
`timescale 1ns/1ps
module sim_mode_timer;
  localparam realtime CLK_P = 4.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [3:0] tap_tick = 4'h0;
  logic       ext_clk_in = 1'b0;
  logic       cap_in = 1'b0;
  logic       irq_ovf, irq_cmp, irq_cap;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];
  item_t cur;
  logic [7:0] act;

  always #(CLK_P/2) clk = ~clk;

  mode_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tap_tick(tap_tick), .ext_clk_in(ext_clk_in), .cap_in(cap_in),
    .irq_ovf(irq_ovf), .irq_cmp(irq_cmp), .irq_cap(irq_cap)
  );

  // Monitor: compares one expected item per cycle, half a period after the edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      act = (cur.sel < 8) ? rdata : {5'b0, irq_cap, irq_cmp, irq_ovf};
      tests++;
      if (act !== cur.exp) begin
        fails++;
        $display("FAIL %s: sel %0d actual %h expected %h", cur.tag, cur.sel, act, cur.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1; addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  // Driver: selects what to observe and pushes the expected value.
  task automatic chk(input int sel, input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    if (sel < 8) addr = sel[2:0];
    it.sel = sel; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Ticks enabled for n+2 clock edges in total.
  task automatic run(input logic [2:0] mode, input logic [2:0] cs, input int n);
    wr(3'd4, {2'b00, mode, cs});
    repeat (n) @(posedge clk);
    wr(3'd4, {2'b00, mode, 3'd0});
  endtask

  task automatic set_cnt(input logic [7:0] hi, input logic [7:0] lo);
    wr(3'd0, lo); wr(3'd1, hi);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    chk(0, 8'h00, "R1 count lo");
    chk(4, 8'h00, "R1 ctrl");
    chk(5, 8'h00, "R1 flags");
    chk(6, 8'h00, "R1 capture");
    chk(8, 8'h00, "R1 irq");

    // R2 stopped counter, CPU access
    set_cnt(8'h34, 8'h12);
    repeat (5) @(posedge clk);
    chk(0, 8'h12, "R2 lo held");
    chk(1, 8'h34, "R2 hi held");

    // R3 8-bit normal wrap: FD -> FE, FF, 00, 01
    wr(3'd0, 8'hFD);
    run(3'b000, 3'd1, 2);
    chk(0, 8'h01, "R3 lo wrapped");
    chk(1, 8'h34, "R3 hi untouched");
    chk(5, 8'h01, "R3 overflow flag");
    wr(3'd5, 8'h01);
    chk(5, 8'h00, "R13 overflow cleared");

    // R4 16-bit normal
    set_cnt(8'h00, 8'hFE);
    run(3'b010, 3'd1, 1);
    chk(0, 8'h01, "R4 lo carry");
    chk(1, 8'h01, "R4 hi carry");
    chk(5, 8'h00, "R4 no flag at 0x00FF");
    set_cnt(8'hFF, 8'hFE);
    run(3'b010, 3'd1, 1);
    chk(0, 8'h01, "R4 lo after wrap");
    chk(1, 8'h00, "R4 hi after wrap");
    chk(8, 8'h01, "R4 irq_ovf");
    wr(3'd5, 8'h01);

    // R5 8-bit CTC: 3 -> 4, 5, 0, 1
    wr(3'd2, 8'h05);
    set_cnt(8'h00, 8'h03);
    run(3'b001, 3'd1, 2);
    chk(0, 8'h01, "R5 restart from 0");
    chk(5, 8'h02, "R5 compare flag");
    wr(3'd5, 8'h02);

    // R6 16-bit CTC, TOP 0x0210: 20E -> 20F, 210, 0, 1
    wr(3'd2, 8'h10); wr(3'd3, 8'h02);
    set_cnt(8'h02, 8'h0E);
    run(3'b011, 3'd1, 2);
    chk(0, 8'h01, "R6 lo");
    chk(1, 8'h00, "R6 hi");
    chk(5, 8'h02, "R6 compare flag");
    wr(3'd5, 8'h02);

    // R7 CTC above TOP: FE -> FF, 00 (ovf), 01
    wr(3'd2, 8'h05);
    set_cnt(8'h00, 8'hFE);
    run(3'b001, 3'd1, 1);
    chk(0, 8'h01, "R7 wrapped at MAX");
    chk(5, 8'h01, "R7 overflow only");
    wr(3'd5, 8'h01);

    // R8 write lands on the tick at TOP
    wr(3'd2, 8'h05);
    wr(3'd0, 8'h04);
    wr(3'd4, 8'h09);
    wr(3'd0, 8'h80);
    chk(0, 8'h81, "R8 write beats clear");
    wr(3'd4, 8'h08);
    chk(5, 8'h00, "R8 no compare flag");

    // R9 compare change used at once: 8 -> 9, 0
    wr(3'd2, 8'h20);
    wr(3'd0, 8'h08);
    wr(3'd2, 8'h09);
    run(3'b001, 3'd1, 0);
    chk(0, 8'h00, "R9 new TOP used");
    chk(5, 8'h02, "R9 compare flag");
    wr(3'd5, 8'h02);

    // R10 prescaler taps
    set_cnt(8'h00, 8'h00);
    tap_tick = 4'b1101;
    run(3'b000, 3'd3, 5);
    chk(0, 8'h00, "R10 other taps ignored");
    tap_tick = 4'b0010;
    run(3'b000, 3'd3, 1);
    chk(0, 8'h03, "R10 selected tap counts");
    tap_tick = 4'b0000;

    // R11 external edges
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h07);
    repeat (3) @(posedge clk);
    #1 ext_clk_in = 1'b1;
    chk(0, 8'h00, "R11 latency edge 1");
    chk(0, 8'h00, "R11 latency edge 2");
    chk(0, 8'h01, "R11 latency edge 3");
    repeat (4) @(posedge clk);
    #1 ext_clk_in = 1'b0;
    repeat (6) @(posedge clk);
    wr(3'd4, 8'h00);
    chk(0, 8'h01, "R11 one rising edge");
    wr(3'd4, 8'h06);
    repeat (2) @(posedge clk);
    #1 ext_clk_in = 1'b1;
    repeat (6) @(posedge clk);
    #1 ext_clk_in = 1'b0;
    repeat (6) @(posedge clk);
    wr(3'd4, 8'h00);
    chk(0, 8'h02, "R11 one falling edge");

    // R12 capture in 16-bit capture mode
    wr(3'd4, 8'h30);
    set_cnt(8'h12, 8'h34);
    #1 cap_in = 1'b1;
    repeat (5) @(posedge clk);
    chk(6, 8'h34, "R12 capture lo");
    chk(7, 8'h12, "R12 capture hi");
    chk(8, 8'h04, "R12 irq_cap");
    wr(3'd5, 8'h04);
    #1 cap_in = 1'b0;
    wr(3'd4, 8'h00);
    set_cnt(8'h00, 8'h99);
    #1 cap_in = 1'b1;
    repeat (5) @(posedge clk);
    #1 cap_in = 1'b0;
    repeat (5) @(posedge clk);
    chk(6, 8'h34, "R12 ignored outside capture");
    chk(5, 8'h00, "R12 no flag outside capture");

    // R13 selective clear
    wr(3'd2, 8'h05);
    wr(3'd0, 8'h04);
    run(3'b001, 3'd1, 0);
    wr(3'd0, 8'hFE);
    run(3'b001, 3'd1, 0);
    chk(5, 8'h03, "R13 both flags");
    chk(8, 8'h03, "R13 irq pair");
    wr(3'd5, 8'h01);
    chk(8, 8'h02, "R13 only overflow cleared");
    wr(3'd5, 8'h02);
    chk(5, 8'h00, "R13 all clear");

    // R14 reserved mode 101: 4 -> 5, 6 without clear
    wr(3'd2, 8'h05);
    wr(3'd0, 8'h04);
    run(3'b101, 3'd1, 0);
    chk(0, 8'h06, "R14 no compare clear");
    chk(5, 8'h00, "R14 no flags");

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung, expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule